// File: doc/BRIEF.md
# Balanced Ternary Add/Subtract Unit with Flags

This block adds or subtracts two 27-trit balanced ternary words and produces a three-trit flag word next to the result. Every trit travels as a 2-bit code. An operation select chooses add, subtract or compare. A single mode trit chooses among three behaviours: plain wrap-around, clamping to the word range, and folding in an incoming carry trit so that words can be chained into wider arithmetic. Compare performs the subtraction only for its flags and leaves the result output as it was.

Result and flags are registered once, one clock after the operands are presented. The flags are handed to an external register that keeps them. That register can feed the carry trit back into the next chained operation.

Top module: `bt_addsub_unit`

## Requirements
- R1: A synchronous active-high reset clears the result and flag outputs to all-Z (every bit 0) on the next rising edge.
- R2: Trit codes are 2'b00 = Z (0), 2'b01 = P (+1) and 2'b11 = N (−1). The code 2'b10 on any input trit is read as Z. No output trit ever carries 2'b10.
- R3: With op 2'b00 (add) and mode Z, the result is a+b wrapped into the range ±(3^27−1)/2, with trit 0 as the least significant trit. It appears one clock after the inputs.
- R4: With op 2'b01 (subtract), the second operand is negated trit by trit (P and N swap, Z stays) and added, so the result is a−b under the same mode rules.
- R5: Mode N (2'b11) adds the carry-in trit for add and subtracts it for subtract. In modes Z and P the carry-in is ignored, and the mode code 2'b10 behaves as mode Z.
- R6: Mode P (2'b01) clamps a result above the range to all-P and a result below it to all-N, and forces the overflow flag to Z.
- R7: Flag trit 0 is the sign of the written result (N negative, Z zero, P positive). In mode P this is the sign of the clamped value.
- R8: Flag trit 1 is N when the exact result lay below the range, P when it lay above, and Z otherwise (outside mode P).
- R9: Flag trit 2 is the carry out of trit 26 in every mode and operation, and flag trits 3 to 26 are Z.
- R10: With op 2'b10 (compare), the flags are computed from a−b with mode and carry-in ignored. The sign flag gives the exact ordering of a and b even when the difference leaves the range, and the result output keeps its previous value.
- R11: The op code 2'b11 behaves exactly as add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 54 | First operand, 27 trits of 2 bits, trit 0 in bits 1:0 |
| b_i | input | 54 | Second operand, same layout |
| op_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 add |
| mode_i | input | 2 | Mode trit: Z wrap, P saturate, N carry-chained |
| cin_i | input | 2 | Incoming carry trit |
| res_o | output | 54 | Registered result word |
| flags_o | output | 54 | Registered flag word: sign, overflow, carry in trits 0..2 |

## Verification
The datapath has no state apart from the output registers. A fault in the carry chain, the negation or the sign scan therefore shows as a wrong result or flag trit on the edge right after the offending operands. Faults in the top trits only show on operands near the range limits, which is why both limits are driven in every mode. A result register that fails to hold across a compare shows on the first compare, because the result then takes the wrapped difference in place of the earlier sum.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t T_Z = 2'b00;
  localparam trit_t T_P = 2'b01;
  localparam trit_t T_N = 2'b11;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_CMP     = 2'b10,
    OP_ADD_ALT = 2'b11
  } op_e;

  // fold the unused code onto zero
  function automatic trit_t canon(input trit_t t);
    return (t == 2'b10) ? T_Z : t;
  endfunction

  function automatic trit_t neg(input trit_t t);
    case (t)
      T_P:     return T_N;
      T_N:     return T_P;
      default: return T_Z;
    endcase
  endfunction

  function automatic logic signed [2:0] tval(input trit_t t);
    case (t)
      T_P:     return 3'sd1;
      T_N:     return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/bt_trit_fa.sv
module bt_trit_fa
  import bt_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);

  logic signed [2:0] tot;

  always_comb begin
    tot = tval(a_i) + tval(b_i) + tval(c_i);
    case (tot)
      -3'sd3:  begin s_o = T_Z; c_o = T_N; end
      -3'sd2:  begin s_o = T_P; c_o = T_N; end
      -3'sd1:  begin s_o = T_N; c_o = T_Z; end
      3'sd1:   begin s_o = T_P; c_o = T_Z; end
      3'sd2:   begin s_o = T_N; c_o = T_P; end
      3'sd3:   begin s_o = T_Z; c_o = T_P; end
      default: begin s_o = T_Z; c_o = T_Z; end
    endcase
  end

endmodule

// File: rtl/bt_ripple_add.sv
module bt_ripple_add
  import bt_pkg::*;
#(
  parameter int W = 27
) (
  input  logic [2*W-1:0] a_i,
  input  logic [2*W-1:0] b_i,
  input  trit_t          c_i,
  output logic [2*W-1:0] s_o,
  output trit_t          c_o
);

  localparam int CW = 2 * (W + 1);

  logic [CW-1:0] cv;

  assign cv[1:0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    bt_trit_fa u_fa (
      .a_i (a_i[2*i+:2]),
      .b_i (b_i[2*i+:2]),
      .c_i (cv[2*i+:2]),
      .s_o (s_o[2*i+:2]),
      .c_o (cv[2*(i+1)+:2])
    );
  end

  assign c_o = cv[2*W+:2];

endmodule

// File: rtl/bt_word_sign.sv
module bt_word_sign
  import bt_pkg::*;
#(
  parameter int W = 27
) (
  input  logic [2*W-1:0] w_i,
  output trit_t          s_o
);

  // the most significant non-zero trit decides the sign
  always_comb begin
    s_o = T_Z;
    for (int i = 0; i < W; i++) begin
      if (w_i[2*i+:2] != T_Z) s_o = w_i[2*i+:2];
    end
  end

endmodule

// File: rtl/bt_addsub_unit.sv
module bt_addsub_unit
  import bt_pkg::*;
#(
  parameter int W = 27
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] a_i,
  input  logic [2*W-1:0] b_i,
  input  logic [1:0]     op_i,
  input  logic [1:0]     mode_i,
  input  logic [1:0]     cin_i,
  output logic [2*W-1:0] res_o,
  output logic [2*W-1:0] flags_o
);

  localparam int BW      = 2 * W;
  localparam int SGN_LSB = 0;
  localparam int OVF_LSB = 2;
  localparam int CRY_LSB = 4;

  op_e     op;
  trit_t   mode, cin_c, cin_eff, carry, wsign, tsign, sign_f, ovf_f;
  logic    is_sub, is_cmp, sat;
  logic [BW-1:0] a_c, b_eff, wrapped, res_nx, flags_nx, all_p, all_n;

  assign op     = op_e'(op_i);
  assign is_cmp = (op == OP_CMP);
  assign is_sub = (op == OP_SUB) || is_cmp;
  assign mode   = is_cmp ? T_Z : canon(mode_i);
  assign sat    = (mode == T_P);
  assign cin_c  = canon(cin_i);
  assign cin_eff = (mode == T_N) ? (is_sub ? neg(cin_c) : cin_c) : T_Z;

  for (genvar g = 0; g < W; g++) begin : g_trit
    assign a_c[2*g+:2]   = canon(a_i[2*g+:2]);
    assign b_eff[2*g+:2] = is_sub ? neg(b_i[2*g+:2]) : canon(b_i[2*g+:2]);
    assign all_p[2*g+:2] = T_P;
    assign all_n[2*g+:2] = T_N;
  end

  bt_ripple_add #(.W(W)) u_add (
    .a_i (a_c),
    .b_i (b_eff),
    .c_i (cin_eff),
    .s_o (wrapped),
    .c_o (carry)
  );

  bt_word_sign #(.W(W)) u_sign (
    .w_i (wrapped),
    .s_o (wsign)
  );

  // a non-zero carry out dominates the sign of the exact result
  assign tsign = (carry != T_Z) ? carry : wsign;

  always_comb begin
    res_nx = wrapped;
    sign_f = wsign;
    ovf_f  = carry;
    if (sat) begin
      ovf_f  = T_Z;
      sign_f = tsign;
      if (carry == T_P)      res_nx = all_p;
      else if (carry == T_N) res_nx = all_n;
    end
    if (is_cmp) sign_f = tsign;
    flags_nx                   = '0;
    flags_nx[SGN_LSB+:2]       = sign_f;
    flags_nx[OVF_LSB+:2]       = ovf_f;
    flags_nx[CRY_LSB+:2]       = carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      if (!is_cmp) res_o <= res_nx;
      flags_o <= flags_nx;
    end
  end

endmodule

// File: rtl/bt_addsub_chk.sv
module bt_addsub_chk #(
  parameter int W = 27
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     op_i,
  input logic [1:0]     mode_i,
  input logic [2*W-1:0] res_o,
  input logic [2*W-1:0] flags_o
);

  function automatic logic has_bad(input logic [2*W-1:0] w);
    for (int i = 0; i < W; i++) begin
      if (w[2*i+:2] == 2'b10) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic all_plus(input logic [2*W-1:0] w);
    for (int i = 0; i < W; i++) begin
      if (w[2*i+:2] != 2'b01) return 1'b0;
    end
    return 1'b1;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (res_o == '0 && flags_o == '0));

  p_legal_codes_r2: assert property (@(posedge clk) disable iff (rst)
    !has_bad(res_o) && !has_bad(flags_o));

  p_sat_no_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == 2'b01 && $past(op_i) != 2'b10)
    |-> flags_o[3:2] == 2'b00);

  p_sat_clamp_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == 2'b01 && $past(op_i) != 2'b10
     && flags_o[5:4] == 2'b01) |-> all_plus(res_o));

  p_ovf_tracks_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode_i) != 2'b01 || $past(op_i) == 2'b10))
    |-> flags_o[3:2] == flags_o[5:4]);

  p_cmp_holds_result_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 2'b10) |-> $stable(res_o));

endmodule

bind bt_addsub_unit bt_addsub_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .mode_i  (mode_i),
  .res_o   (res_o),
  .flags_o (flags_o)
);

// File: tb/tb_bt_addsub_unit.sv
`timescale 1ns/1ps
module tb_bt_addsub_unit;

  localparam int W  = 27;
  localparam int BW = 2 * W;
  localparam longint P3W = 64'sd7625597484987;
  localparam longint MX  = 64'sd3812798742493;
  localparam int NV = 14;

  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, CMP = 2'b10, ADD2 = 2'b11;
  localparam logic [1:0] TZ = 2'b00, TP = 2'b01, TN = 2'b11, TX = 2'b10;

  localparam longint VA [NV] = '{5, 100, MX, -MX, MX, -MX, MX, 10, -MX, 42, MX, 3, 7, MX};
  localparam longint VB [NV] = '{7, -250, 1, -1, 1, 1, 0, 3, -MX, 42, -1, 9, 2, MX};
  localparam logic [1:0] VOP [NV] = '{ADD, SUB, ADD, ADD, ADD, SUB, ADD, SUB, ADD, CMP, CMP, ADD2, ADD, ADD};
  localparam logic [1:0] VMD [NV] = '{TZ, TZ, TZ, TZ, TP, TP, TN, TN, TZ, TP, TZ, TZ, TX, TP};
  localparam logic [1:0] VCI [NV] = '{TZ, TP, TZ, TZ, TP, TN, TP, TN, TP, TP, TN, TZ, TP, TZ};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BW-1:0] a = '0, b = '0;
  logic [1:0] op = 2'b00, mode = 2'b00, cin = 2'b00;
  logic [BW-1:0] res, flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [BW-1:0] exp_res = '0;

  always #2 clk = ~clk;

  bt_addsub_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op), .mode_i(mode),
    .cin_i(cin), .res_o(res), .flags_o(flags)
  );

  function automatic logic [BW-1:0] enc(longint v);
    logic [BW-1:0] w = '0;
    longint x = v;
    longint r;
    for (int i = 0; i < W; i++) begin
      r = x % 3;
      if (r == 2) r = -1;
      else if (r == -2) r = 1;
      x = (x - r) / 3;
      w[2*i+:2] = (r == 1) ? 2'b01 : (r == -1) ? 2'b11 : 2'b00;
    end
    return w;
  endfunction

  function automatic longint tv(logic [1:0] c);
    return (c == 2'b01) ? 64'sd1 : (c == 2'b11) ? -64'sd1 : 64'sd0;
  endfunction

  function automatic longint sgn(longint v);
    return (v > 0) ? 64'sd1 : (v < 0) ? -64'sd1 : 64'sd0;
  endfunction

  function automatic longint rnd_val();
    longint v = 0;
    for (int i = 0; i < W; i++) v = v * 3 + longint'($urandom_range(2, 0)) - 1;
    return v;
  endfunction

  task automatic chk(string tag, logic [BW-1:0] got, logic [BW-1:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, expv);
    end
  endtask

  task automatic apply(logic [BW-1:0] aw, logic [BW-1:0] bw, longint av, longint bv,
                       logic [1:0] o, logic [1:0] m, logic [1:0] c, string tag);
    longint mv, t, w, co, r, sg, ov;
    bit sub, cmp;
    sub = (o == SUB) || (o == CMP);
    cmp = (o == CMP);
    mv  = cmp ? 64'sd0 : tv(m);
    t   = av + (sub ? -bv : bv);
    if (mv == -1) t = t + (sub ? -tv(c) : tv(c));
    co = 0; w = t;
    if (t > MX) begin co = 1; w = t - P3W; end
    else if (t < -MX) begin co = -1; w = t + P3W; end
    if (mv == 1) begin
      r  = (co == 1) ? MX : (co == -1) ? -MX : w;
      sg = sgn(t); ov = 0;
    end else begin
      r = w; sg = sgn(w); ov = co;
    end
    if (cmp) sg = sgn(t);
    else exp_res = enc(r);
    @(negedge clk);
    a = aw; b = bw; op = o; mode = m; cin = c;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " result"}, res, exp_res);
    chk({tag, " flags"}, flags, enc(sg + 3 * ov + 9 * co));
  endtask

  task automatic run(longint av, longint bv, logic [1:0] o, logic [1:0] m,
                     logic [1:0] c, string tag);
    apply(enc(av), enc(bv), av, bv, o, m, c, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] odd_a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1 reset result", res, '0);
    chk("R1 reset flags", flags, '0);
    rst = 1'b0;

    // vector table: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      run(VA[i], VB[i], VOP[i], VMD[i], VCI[i], $sformatf("R3-R11 vector %0d", i));
    end

    // R2: code 10 on inputs reads as Z (a = +1 with all upper trits 10)
    odd_a = '0;
    for (int i = 1; i < W; i++) odd_a[2*i+:2] = 2'b10;
    odd_a[1:0] = 2'b01;
    apply(odd_a, enc(2), 1, 2, ADD, TZ, TZ, "R2 illegal code as Z");

    // R5: carry ignored in mode Z, applied in mode N for add and sub
    run(20, 5, ADD, TZ, TN, "R5 carry ignored");
    run(20, 5, ADD, TN, TN, "R5 carry add");
    run(20, 5, SUB, TN, TP, "R5 carry sub");

    // R6: saturating low limit, exact limit not clamped
    run(-MX, -MX, ADD, TP, TZ, "R6 clamp low");
    run(MX - 1, 1, ADD, TP, TZ, "R6 exact max");

    // R10: compare below range keeps previous result
    run(-MX, 1, CMP, TN, TP, "R10 compare low");

    // random sweep: R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < 40; k++) begin
      for (int s = 0; s < 9; s++) begin
        logic [1:0] o, m, c;
        o = (s / 3 == 0) ? ADD : (s / 3 == 1) ? SUB : CMP;
        m = (s % 3 == 0) ? TZ : (s % 3 == 1) ? TP : TN;
        c = (k % 3 == 0) ? TZ : (k % 3 == 1) ? TP : TN;
        run(rnd_val(), rnd_val(), o, m, c, "R3-R10 random");
      end
    end

    // R1: reset in mid-run clears outputs again
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid reset result", res, '0);
    chk("R1 mid reset flags", flags, '0);
    rst = 1'b0;
    exp_res = '0;
    run(1, 1, ADD, TZ, TZ, "R3 after reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule